// File: doc/BRIEF.md
# Four-Bank Byte-Lane Load/Store Unit

This block connects the memory stage of a 32-bit integer pipeline to a data store built from four 8-bit banks. All four banks are read and written in the same cycle. A request gives a byte address, store data, a three-bit access kind, a read request and a write request. For a store, the block moves the data onto the right byte lanes and raises one write strobe per bank. For a load, it reads all four banks at the same row. It then picks the addressed byte or halfword and extends it to 32 bits, with the sign bit or with zeros. Address bits [1:0] give the starting lane. The remaining low address bits select the bank row.

A small controller tracks each request. Its register is enumerated and moves through three states. CTL_IDLE means the last cycle carried no accepted load and no fault. CTL_RESP means a load was accepted on the previous edge, so its data is valid now. CTL_FAULT means the previous request was rejected. The transitions are evaluated on every clock edge, from any state:
- A request that is misaligned, uses an unassigned kind, or names an address beyond the banks goes to CTL_FAULT.
- Otherwise, an accepted read goes to CTL_RESP.
- Otherwise, the controller goes to CTL_IDLE.

Reset forces CTL_IDLE.

Top module: `lanemem_top`

## Requirements
- R1: The bank row output equals the byte address bits [ROW_W+1:2]. Address bits [1:0] give the starting lane, and lane 0 is bits [7:0] of the 32-bit bank data.
- R2: A byte store (kind 000 or 100) raises exactly one strobe, bit `addr[1:0]`. The store byte appears on that lane of the bank write data.
- R3: A halfword store (kind 001 or 101) at an even address raises strobes `2'b11 << addr[1:0]`. The low store byte goes on the lower lane and the high store byte on the next lane.
- R4: A word store (kind 010) at a word-aligned address raises all four strobes and writes all four store bytes in little-endian order.
- R5: A request is rejected in any of these cases:
  - a halfword kind with address bit 0 set;
  - a word kind with address bits [1:0] not 00;
  - kind 011, 110 or 111;
  - any address bit above ROW_W+1 set.

  A rejected request raises no strobe and changes no bank. It gives no load response and leaves the load data unchanged. The fault output is high in the cycle after the rejected request.
- R6: The load result appears, with the valid output high for exactly one cycle, in the cycle after the clock edge that accepted the read.
- R7: Signed loads fill bits above the loaded field with its top bit: LB is kind 000 (8 bits) and LH is kind 001 (16 bits). LW (kind 010) returns the full word.
- R8: Unsigned loads fill bits above the loaded field with zeros: LBU is kind 100 and LHU is kind 101.
- R9: Loads assemble bytes little-endian, so the byte at the lowest address lands in bits [7:0].
- R10: When read and write are both asserted in one cycle, both are carried out at the same row. The load returns the contents from before that write.
- R11: Out of reset, the valid and fault outputs are low and the load data is zero.
- R12: With the write request low, all bank strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| req_kind | input | 3 | Access kind: size in [1:0], unsigned flag in [2] |
| req_rd | input | 1 | Load request |
| req_wr | input | 1 | Store request |
| rsp_rdata | output | 32 | Extended load result |
| rsp_valid | output | 1 | Load result valid this cycle |
| rsp_fault | output | 1 | Previous request was rejected |
| bank_row | output | ROW_W | Row address driven to all banks |
| bank_wdata | output | 32 | Lane-steered write data |
| bank_wstrb | output | 4 | Per-bank write enable |

## Verification
A load and a store can land on the same cycle and the same bank row. The bench provokes this in two steps:
1. It fills a row with a known word.
2. It asserts read and write together at that address with a different word.

The bench then checks three things. All four strobes must rise during the request. The load returned on the next cycle must equal the old word, not the new one. A separate load afterwards must return the new word, which shows the write still took effect.

// File: rtl/lanemem_pkg.sv
package lanemem_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD,
        SZ_NONE
    } size_e;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_RESP,
        CTL_FAULT
    } ctl_state_e;

    // Kind code to access size; unassigned codes map to SZ_NONE.
    function automatic size_e kind_size(input logic [2:0] kind);
        size_e s;
        case (kind)
            3'b000, 3'b100: s = SZ_BYTE;
            3'b001, 3'b101: s = SZ_HALF;
            3'b010:         s = SZ_WORD;
            default:        s = SZ_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lane_steer.sv
module lane_steer
    import lanemem_pkg::*;
(
    input  logic [2:0]        kind,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  strb_raw,
    output logic [DATA_W-1:0] lane_data,
    output logic              fmt_bad
);

    size_e sz;

    always_comb begin
        sz = kind_size(kind);
        strb_raw  = '0;
        lane_data = wdata;
        fmt_bad   = 1'b0;
        unique case (sz)
            SZ_BYTE: begin
                strb_raw  = LANES'(1) << off;
                lane_data = {LANES{wdata[LANE_W-1:0]}};
            end
            SZ_HALF: begin
                fmt_bad   = off[0];
                strb_raw  = LANES'(3) << off;
                lane_data = {(LANES/2){wdata[2*LANE_W-1:0]}};
            end
            SZ_WORD: begin
                fmt_bad   = (off != '0);
                strb_raw  = '1;
                lane_data = wdata;
            end
            SZ_NONE: begin
                fmt_bad   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/lane_gather.sv
module lane_gather
    import lanemem_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic [OFF_W-1:0]  off_q,
    input  logic [2:0]        kind_q,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] shifted;
    logic              zero_fill;
    size_e             sz;

    always_comb begin
        shifted   = raw >> {off_q, 3'b000};
        zero_fill = kind_q[2];
        sz        = kind_size(kind_q);
        unique case (sz)
            SZ_BYTE: rdata = zero_fill
                ? {{(DATA_W-LANE_W){1'b0}}, shifted[LANE_W-1:0]}
                : {{(DATA_W-LANE_W){shifted[LANE_W-1]}}, shifted[LANE_W-1:0]};
            SZ_HALF: rdata = zero_fill
                ? {{(DATA_W-2*LANE_W){1'b0}}, shifted[2*LANE_W-1:0]}
                : {{(DATA_W-2*LANE_W){shifted[2*LANE_W-1]}}, shifted[2*LANE_W-1:0]};
            SZ_WORD: rdata = raw;
            SZ_NONE: rdata = '0;
        endcase
    end

endmodule

// File: rtl/byte_bank.sv
module byte_bank
    import lanemem_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ROW_W-1:0]  row,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);

    localparam int DEPTH = 1 << ROW_W;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[row] <= din;
    end

    // Read port registered; returns the pre-write value on a same-row clash.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  dout <= '0;
        else if (re) dout <= cells[row];
    end

endmodule

// File: rtl/lanemem_ctrl.sv
module lanemem_ctrl
    import lanemem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic wr,
    input  logic req_bad,
    output logic load_fire,
    output logic rsp_valid,
    output logic rsp_fault
);

    ctl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_fire = rd && !req_bad;
        if ((rd || wr) && req_bad) state_d = CTL_FAULT;
        else if (rd)               state_d = CTL_RESP;
        else                       state_d = CTL_IDLE;
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        unique case (state_q)
            CTL_IDLE:  ;
            CTL_RESP:  rsp_valid = 1'b1;
            CTL_FAULT: rsp_fault = 1'b1;
            default:   ;
        endcase
    end

    // R6
    valid_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd));

    // R5
    valid_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault));

endmodule

// File: rtl/lanemem_top.sv
module lanemem_top
    import lanemem_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ROW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [2:0]        req_kind,
    input  logic              req_rd,
    input  logic              req_wr,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [ROW_W-1:0]  bank_row,
    output logic [31:0]       bank_wdata,
    output logic [3:0]        bank_wstrb
);

    localparam int ROW_LSB = OFF_W;
    localparam int ROW_MSB = ROW_W + OFF_W - 1;

    logic [OFF_W-1:0]  off;
    logic              range_bad, fmt_bad, req_bad, load_fire;
    logic [LANES-1:0]  strb_raw;
    logic [DATA_W-1:0] raw_word;
    logic [OFF_W-1:0]  off_q;
    logic [2:0]        kind_q;

    assign off       = req_addr[OFF_W-1:0];
    assign bank_row  = req_addr[ROW_MSB:ROW_LSB];
    assign range_bad = |req_addr[ADDR_W-1:ROW_MSB+1];
    assign req_bad   = fmt_bad | range_bad;
    assign bank_wstrb = (req_wr && !req_bad) ? strb_raw : '0;

    lane_steer u_steer (
        .kind      (req_kind),
        .off       (off),
        .wdata     (req_wdata),
        .strb_raw  (strb_raw),
        .lane_data (bank_wdata),
        .fmt_bad   (fmt_bad)
    );

    lanemem_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (req_rd),
        .wr        (req_wr),
        .req_bad   (req_bad),
        .load_fire (load_fire),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            kind_q <= 3'b010;
        end else if (load_fire) begin
            off_q  <= off;
            kind_q <= req_kind;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        byte_bank #(.ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_wstrb[g]),
            .re    (load_fire),
            .row   (bank_row),
            .din   (bank_wdata[g*LANE_W +: LANE_W]),
            .dout  (raw_word[g*LANE_W +: LANE_W])
        );
    end

    lane_gather u_gather (
        .raw    (raw_word),
        .off_q  (off_q),
        .kind_q (kind_q),
        .rdata  (rsp_rdata)
    );

    // R12
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_wr |-> bank_wstrb == '0);

    // R5
    fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> $past(bank_wstrb) == '0);

    // R2
    byte_one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_kind[1:0] == 2'b00 && bank_wstrb != '0) |-> $countones(bank_wstrb) == 1);

    // R4
    word_all_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_kind == 3'b010 && bank_wstrb != '0) |-> bank_wstrb == 4'hF);

    // R8
    ubyte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind) == 3'b100) |-> rsp_rdata[31:8] == '0);

endmodule

// File: tb/tb_lanemem_top.sv
module tb_lanemem_top;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 32;
    localparam int ROW_W  = 8;
    localparam int NBYTES = 4 << ROW_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [2:0]        req_kind = 3'b010;
    logic              req_rd = 1'b0;
    logic              req_wr = 1'b0;
    logic [31:0]       rsp_rdata;
    logic              rsp_valid, rsp_fault;
    logic [ROW_W-1:0]  bank_row;
    logic [31:0]       bank_wdata;
    logic [3:0]        bank_wstrb;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] ref_mem [NBYTES];

    always #(CLK_P/2) clk = ~clk;

    lanemem_top #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_kind(req_kind), .req_rd(req_rd), .req_wr(req_wr),
        .rsp_rdata(rsp_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .bank_row(bank_row), .bank_wdata(bank_wdata), .bank_wstrb(bank_wstrb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int kind_bytes(input logic [2:0] k);
        case (k)
            3'b000, 3'b100: return 1;
            3'b001, 3'b101: return 2;
            default:        return 4;
        endcase
    endfunction

    function automatic logic [31:0] ref_load(input int a, input logic [2:0] k);
        int n = kind_bytes(k);
        logic [31:0] v = '0;
        for (int i = 0; i < n; i++) v[8*i +: 8] = ref_mem[a + i];
        if (!k[2] && n < 4) begin
            for (int b = 8*n; b < 32; b++) v[b] = v[8*n - 1];
        end
        return v;
    endfunction

    task automatic idle();
        req_rd = 1'b0; req_wr = 1'b0; req_wdata = '0;
    endtask

    task automatic do_store(input int a, input logic [31:0] d, input logic [2:0] k, input string tag);
        int n = kind_bytes(k);
        int off = a % 4;
        logic [3:0] es = 4'((1 << n) - 1) << off;
        req_addr = ADDR_W'(a); req_wdata = d; req_kind = k; req_wr = 1'b1; req_rd = 1'b0;
        #1;
        chk({tag, " strobes"}, {28'b0, bank_wstrb}, {28'b0, es});
        chk("R1 row", {24'b0, bank_row}, 32'(a / 4));
        for (int i = 0; i < n; i++)
            chk({tag, " lane data"}, {24'b0, bank_wdata[8*(off+i) +: 8]}, {24'b0, d[8*i +: 8]});
        for (int i = 0; i < n; i++) ref_mem[a + i] = d[8*i +: 8];
        @(negedge clk);
        chk({tag, " no fault"}, {31'b0, rsp_fault}, 32'd0);
        idle();
    endtask

    task automatic do_load(input int a, input logic [2:0] k, input string tag);
        req_addr = ADDR_W'(a); req_kind = k; req_rd = 1'b1; req_wr = 1'b0;
        #1;
        chk("R12 load no strobe", {28'b0, bank_wstrb}, 32'd0);
        @(negedge clk);
        chk("R6 valid", {31'b0, rsp_valid}, 32'd1);
        chk(tag, rsp_rdata, ref_load(a, k));
        idle();
        @(negedge clk);
        chk("R6 valid one cycle", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic do_reject(input logic rd, input logic wr, input int a, input logic [2:0] k);
        logic [31:0] prev = rsp_rdata;
        req_addr = ADDR_W'(a); req_kind = k; req_rd = rd; req_wr = wr; req_wdata = 32'hDEAD_BEEF;
        #1;
        chk("R5 reject no strobe", {28'b0, bank_wstrb}, 32'd0);
        @(negedge clk);
        chk("R5 fault flag", {31'b0, rsp_fault}, 32'd1);
        chk("R5 no response", {31'b0, rsp_valid}, 32'd0);
        chk("R5 data held", rsp_rdata, prev);
        idle();
        @(negedge clk);
        chk("R5 fault one cycle", {31'b0, rsp_fault}, 32'd0);
    endtask

    task automatic sweep_row(input int r);
        for (int o = 0; o < 4; o++) begin
            do_load(4*r + o, 3'b000, "R7 LB");
            do_load(4*r + o, 3'b100, "R8 LBU");
        end
        for (int o = 0; o < 4; o += 2) begin
            do_load(4*r + o, 3'b001, "R7 LH");
            do_load(4*r + o, 3'b101, "R8 LHU");
        end
        do_load(4*r, 3'b010, "R9 LW");
    endtask

    task automatic t_reset();
        chk("R11 valid", {31'b0, rsp_valid}, 32'd0);
        chk("R11 fault", {31'b0, rsp_fault}, 32'd0);
        chk("R11 data", rsp_rdata, 32'd0);
    endtask

    task automatic t_bytes();
        do_store(12, 32'h0000_0081, 3'b000, "R2 SB");
        do_store(13, 32'hFFFF_FF7F, 3'b000, "R2 SB");
        do_store(14, 32'h0000_00C3, 3'b100, "R2 SB");
        do_store(15, 32'h1234_5605, 3'b000, "R2 SB");
        sweep_row(3);
    endtask

    task automatic t_halves();
        do_store(20, 32'h0000_BEEF, 3'b001, "R3 SH");
        do_store(22, 32'hAAAA_7234, 3'b101, "R3 SH");
        sweep_row(5);
        do_store(24, 32'h0000_8001, 3'b001, "R3 SH");
        do_store(26, 32'h0000_00FF, 3'b001, "R3 SH");
        sweep_row(6);
    endtask

    task automatic t_words();
        do_store(28, 32'h8001_7FFE, 3'b010, "R4 SW");
        sweep_row(7);
        do_store(29, 32'h0000_0055, 3'b000, "R2 SB into word");
        sweep_row(7);
        do_store(0, 32'h0102_0304, 3'b010, "R4 SW");
        do_store(4*255, 32'hF0E1_D2C3, 3'b010, "R4 SW top row");
        sweep_row(0);
        sweep_row(255);
    endtask

    task automatic t_reject();
        do_load(28, 3'b010, "R9 LW setup");
        do_reject(1'b0, 1'b1, 29, 3'b001);
        do_reject(1'b0, 1'b1, 31, 3'b101);
        do_reject(1'b0, 1'b1, 30, 3'b010);
        do_reject(1'b0, 1'b1, 29, 3'b010);
        do_reject(1'b1, 1'b0, 31, 3'b001);
        do_reject(1'b1, 1'b0, 26, 3'b010);
        do_reject(1'b0, 1'b1, 28, 3'b011);
        do_reject(1'b1, 1'b0, 28, 3'b110);
        do_reject(1'b1, 1'b1, 28, 3'b111);
        do_reject(1'b0, 1'b1, NBYTES + 28, 3'b010);
        do_reject(1'b1, 1'b0, NBYTES + 28, 3'b000);
        sweep_row(7);
    endtask

    task automatic t_clash();
        logic [31:0] old_w;
        do_store(36, 32'h1122_3344, 3'b010, "R4 SW");
        old_w = ref_load(36, 3'b010);
        req_addr = ADDR_W'(36); req_kind = 3'b010; req_wdata = 32'hA5A5_5A5A;
        req_rd = 1'b1; req_wr = 1'b1;
        #1;
        chk("R10 clash strobes", {28'b0, bank_wstrb}, 32'h0000_000F);
        for (int i = 0; i < 4; i++) ref_mem[36 + i] = req_wdata[8*i +: 8];
        @(negedge clk);
        chk("R10 clash valid", {31'b0, rsp_valid}, 32'd1);
        chk("R10 clash old data", rsp_rdata, old_w);
        idle();
        @(negedge clk);
        do_load(36, 3'b010, "R10 new data after clash");
    endtask

    task automatic t_idle_strobe();
        req_addr = ADDR_W'(40); req_kind = 3'b010; req_wdata = 32'hFFFF_FFFF;
        req_wr = 1'b0; req_rd = 1'b0;
        #1;
        chk("R12 idle strobes", {28'b0, bank_wstrb}, 32'd0);
        @(negedge clk);
        chk("R12 idle no valid", {31'b0, rsp_valid}, 32'd0);
        idle();
        do_store(40, 32'h0BAD_F00D, 3'b010, "R4 SW");
        req_addr = ADDR_W'(40); req_wdata = 32'h7777_7777; req_kind = 3'b000;
        @(negedge clk);
        idle();
        do_load(40, 3'b010, "R12 row unchanged");
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NBYTES; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_halves();
        t_words();
        t_reject();
        t_clash();
        t_idle_strobe();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule